// File: doc/BRIEF.md
# Linked Descriptor Transfer Sequencer

This block sequences serial transfers from a small on-chip list of 32-bit transfer descriptors. Software fills a sixteen-entry descriptor file, chooses the entry where processing begins, turns on descriptor mode and issues a start command. The sequencer then hands the current descriptor to a serial engine as one command. It counts the engine's unit completions until the descriptor's unit count is used up. It then moves to the entry named by that descriptor's next-index field, and keeps going until it finishes an entry that carries the end-of-chain flag.

Each descriptor carries:
- the lane mode;
- the transmit mode;
- a receive enable;
- a unit size;
- a bit-unit option for dummy clocks;
- a flag that releases chip select;
- the next index;
- the end-of-chain flag;
- a 15-bit unit count.

An entry whose options cannot run together is refused: the block raises a sticky program-error flag and leaves the entry unrun. A stop command ends a running chain at the next unit boundary. Status shows sticky completion and error flags, a busy flag and the index of the current or most recent descriptor. Software clears the two sticky flags by writing ones.

The bus side is a plain single-cycle write port with a combinational read-back. The engine side uses three signals: a level "command valid" with the descriptor word, a per-unit completion pulse from the engine, and a "command done" pulse back from the sequencer.

Top module: `desc_chain_seq`

## Requirements
- R1: After reset, status reads 0, `cmd_valid` is 0 and `cs_n` is 1.
- R2: Register map, by word address:
  - addresses 0..15 are the descriptor file;
  - 16 is control (bit 0 enables descriptor mode, bits [7:4] hold the first index);
  - 17 is status;
  - 18 is the command register (bit 0 start, bit 1 stop).

  Descriptors and control read back what was written.
- R3: A start with descriptor mode enabled and the block idle makes it active, with the current index set to the first index. From the next cycle `cmd_valid` is 1 and `cmd_desc` equals that descriptor. A start is ignored when descriptor mode is disabled or the block is already active.
- R4: Unit counting. A descriptor finishes on the Nth accepted `unit_done`, where N is its count field, bits [31:17], and `cmd_done` is 1 only in that cycle. Counts up to the largest field value, 0x7FFF, are honoured.
- R5: When a descriptor finishes, chaining depends on its end-of-chain flag.
  - With bit 16 clear, processing continues at the index in bits [15:12].
  - With bit 16 set, the active flag clears and the done flag sets on the same edge.
- R6: A descriptor is a program error when any of these holds:
  - the transmit mode (bits [3:2]) is non-zero and receive enable (bit 6) is set;
  - the unit size (bits [11:10]) is 3;
  - the count is 0.

  Such a descriptor never raises `cmd_valid`. The program-error flag sets, active clears, and done stays unchanged.
- R7: Chip select follows the release flag, bit 8.
  - A finished descriptor with bit 8 set releases chip select. When the chain continues, `cs_n` is 1 and `cmd_valid` is 0 for exactly one cycle before the next descriptor runs.
  - Without bit 8, `cs_n` stays 0, including after the chain ends.
- R8: Stop behaviour depends on whether the block is active.
  - While active, stop takes effect at the next accepted `unit_done`: active clears, done sets and `cs_n` goes to 1, and `cmd_done` is not raised for the unfinished descriptor.
  - While idle, stop releases a held chip select.
- R9: Status layout is done at bit 0, program error at bit 1, active at bit 2 and the current index at bits [15:12]. Writing 1 to bit 0 or bit 1 clears that flag. A flag being set in the same cycle as its clear stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| cmd_valid | output | 1 | Current descriptor is being executed by the engine |
| cmd_desc | output | 32 | Current descriptor word |
| unit_done | input | 1 | Engine finished one unit (counted only while `cmd_valid`) |
| cmd_done | output | 1 | Pulse: current descriptor finished its last unit |
| cs_n | output | 1 | Active-low chip select |

## Verification
Two pairs of events can fall on the same clock edge. The first pair is a software write-one-to-clear of status and the completion of a chain's final unit. The bench provokes this by driving the status write and the last `unit_done` in the same cycle, then expects the done flag still set on read-back. The second pair is a stop command and a unit boundary. The bench issues stop in a cycle between units and checks two things: the descriptor keeps running until the following `unit_done`, and that pulse ends the chain without a `cmd_done`.

// File: rtl/desc_chain_seq.sv
module desc_chain_seq #(
  parameter int IDX_W = 4,
  parameter int AW    = 5,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          cmd_valid,
  output logic [DW-1:0] cmd_desc,
  input  logic          unit_done,
  output logic          cmd_done,
  output logic          cs_n
);
  localparam int NDESC   = 1 << IDX_W;
  localparam int NXT_LSB = 12;
  localparam int LAST_B  = NXT_LSB + IDX_W;
  localparam int CNT_LSB = LAST_B + 1;
  localparam int CNT_W   = DW - CNT_LSB;
  localparam logic [AW-1:0] A_CTRL = AW'(NDESC);
  localparam logic [AW-1:0] A_STAT = AW'(NDESC + 1);
  localparam logic [AW-1:0] A_CMD  = AW'(NDESC + 2);

  logic [DW-1:0]    dfile [NDESC];
  logic             en, active, done, perr, stop_pend, cs_hold, rel_gap;
  logic [IDX_W-1:0] first_idx, cur_idx;
  logic [CNT_W-1:0] ucnt;

  wire [DW-1:0]    cur      = dfile[cur_idx];
  wire [CNT_W-1:0] cur_cnt  = cur[DW-1:CNT_LSB];
  wire [IDX_W-1:0] cur_next = cur[LAST_B-1:NXT_LSB];
  wire             cur_last = cur[LAST_B];
  wire             cur_rel  = cur[8];
  wire             cur_err  = (cur[3:2] != 2'b00 && cur[6]) || cur[11:10] == 2'b11 || cur_cnt == '0;
  wire             last_unit = (ucnt + CNT_W'(1)) == cur_cnt;
  wire             is_cmd   = bus_wr && bus_addr == A_CMD;
  wire             start    = is_cmd && bus_wdata[0];
  wire             stop     = is_cmd && bus_wdata[1];
  wire             beat     = cmd_valid && unit_done;

  assign cmd_valid = active && !cur_err && !rel_gap;
  assign cmd_desc  = cur;
  assign cmd_done  = beat && !stop_pend && last_unit;
  assign cs_n      = !(cmd_valid || cs_hold);

  always_comb begin
    bus_rdata = '0;
    if (bus_addr < A_CTRL)       bus_rdata = dfile[bus_addr[IDX_W-1:0]];
    else if (bus_addr == A_CTRL) bus_rdata = DW'({first_idx, 3'b000, en});
    else if (bus_addr == A_STAT) bus_rdata = DW'({cur_idx, 9'b0, active, perr, done}) << (NXT_LSB - 12);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NDESC; i++) dfile[i] <= '0;
      en <= 1'b0; active <= 1'b0; done <= 1'b0; perr <= 1'b0;
      stop_pend <= 1'b0; cs_hold <= 1'b0; rel_gap <= 1'b0;
      first_idx <= '0; cur_idx <= '0; ucnt <= '0;
    end else begin
      rel_gap <= cmd_done && cur_rel;
      if (bus_wr) begin
        if (bus_addr < A_CTRL) dfile[bus_addr[IDX_W-1:0]] <= bus_wdata;
        if (bus_addr == A_CTRL) begin
          en        <= bus_wdata[0];
          first_idx <= bus_wdata[IDX_W+3:4];
        end
        if (bus_addr == A_STAT) begin
          if (bus_wdata[0]) done <= 1'b0;
          if (bus_wdata[1]) perr <= 1'b0;
        end
      end
      if (start && en && !active) begin
        active  <= 1'b1;
        cur_idx <= first_idx;
        ucnt    <= '0;
      end
      if (stop) begin
        if (active) stop_pend <= 1'b1;
        else        cs_hold   <= 1'b0;
      end
      if (active && cur_err) begin
        perr      <= 1'b1;
        active    <= 1'b0;
        stop_pend <= 1'b0;
      end else if (beat) begin
        if (stop_pend) begin
          active    <= 1'b0;
          done      <= 1'b1;
          cs_hold   <= 1'b0;
          stop_pend <= 1'b0;
          ucnt      <= '0;
        end else if (last_unit) begin
          ucnt    <= '0;
          cs_hold <= !cur_rel;
          if (cur_last) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            cur_idx <= cur_next;
          end
        end else begin
          ucnt <= ucnt + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/desc_chain_seq_chk.sv
module desc_chain_seq_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             active,
  input logic             done,
  input logic             perr,
  input logic             cmd_valid,
  input logic             cmd_done,
  input logic             cs_n,
  input logic             cur_last,
  input logic [IDX_W-1:0] cur_idx,
  input logic [IDX_W-1:0] cur_next
);
  p_valid_needs_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> active);

  p_last_ends_chain_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done && cur_last |=> !active && done);

  p_next_index_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done && !cur_last |=> cur_idx == $past(cur_next));

  p_error_halts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(perr) |-> !active && !cmd_valid);

  p_cs_low_running_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !cs_n);

  p_done_only_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !active);
endmodule

bind desc_chain_seq desc_chain_seq_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .active(active), .done(done), .perr(perr),
  .cmd_valid(cmd_valid), .cmd_done(cmd_done), .cs_n(cs_n),
  .cur_last(cur_last), .cur_idx(cur_idx), .cur_next(cur_next)
);

// File: tb/desc_chain_seq_tb.sv
module desc_chain_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] A_CTRL = 5'd16, A_STAT = 5'd17, A_CMD = 5'd18;

  logic        clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, unit_done = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, cmd_desc;
  logic        cmd_valid, cmd_done, cs_n;
  int total = 0, bad = 0, cyc = 0;

  desc_chain_seq u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmd_valid(cmd_valid),
    .cmd_desc(cmd_desc), .unit_done(unit_done), .cmd_done(cmd_done), .cs_n(cs_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [31:0] mk(input logic [14:0] cnt, input logic last,
      input logic [3:0] nxt, input logic [1:0] usz, input logic rel,
      input logic rx, input logic [1:0] tx);
    return {cnt, last, nxt, usz, 1'b0, rel, 1'b0, rx, 2'b00, tx, 2'b00};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic exp_done, input string req);
    @(negedge clk);
    unit_done = 1'b1;
    #1;
    check({req, " valid"}, 32'(cmd_valid), 32'd1);
    check({req, " cmd_done"}, 32'(cmd_done), 32'(exp_done));
    @(negedge clk);
    unit_done = 1'b0;
  endtask

  initial begin
    logic [31:0] s, dd [3];
    logic [3:0]  ix [3];
    int          cn [3];
    int          hits, hit_at;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(A_STAT, s);
    check("R1 status", s, 32'd0);
    check("R1 cmd_valid", 32'(cmd_valid), 32'd0);
    check("R1 cs_n", 32'(cs_n), 32'd1);

    for (int f = 0; f < 16; f++) begin
      for (int k = 0; k < 3; k++) begin
        ix[k] = 4'(f + k);
        cn[k] = 1 + ((f + k) % 3);
      end
      dd[0] = mk(15'(cn[0]), 1'b0, ix[1], 2'(f % 3), 1'b1, 1'b0, 2'd1);
      dd[1] = mk(15'(cn[1]), 1'b0, ix[2], 2'd0, 1'b0, 1'b1, 2'd0);
      dd[2] = mk(15'(cn[2]), 1'b1, 4'(f * 5), 2'd2, 1'b1, 1'b0, 2'd2);
      for (int k = 0; k < 3; k++) wr({1'b0, ix[k]}, dd[k]);
      wr(A_CTRL, {24'd0, 4'(f), 4'd1});
      rd(A_CTRL, s);
      check("R2 ctrl readback", s, {24'd0, 4'(f), 4'd1});
      rd({1'b0, ix[1]}, s);
      check("R2 desc readback", s, dd[1]);
      wr(A_CMD, 32'd1);
      for (int k = 0; k < 3; k++) begin
        check("R3 cmd_desc", cmd_desc, dd[k]);
        rd(A_STAT, s);
        check("R9 index/active", s, {16'd0, ix[k], 12'h004});
        for (int u = 0; u < cn[k]; u++) pulse(u == cn[k] - 1, "R4");
        if (k == 0) begin
          check("R7 gap cs_n", 32'(cs_n), 32'd1);
          check("R7 gap valid", 32'(cmd_valid), 32'd0);
        end else if (k == 1) begin
          check("R7 held cs_n", 32'(cs_n), 32'd0);
        end
      end
      rd(A_STAT, s);
      check("R5 chain end status", s, {16'd0, ix[2], 12'h001});
      check("R7 released", 32'(cs_n), 32'd1);
      wr(A_STAT, 32'h3);
      rd(A_STAT, s);
      check("R9 w1c", s, {16'd0, ix[2], 12'h000});
    end

    wr(5'd3, mk(15'd4, 1'b1, 4'd0, 2'd0, 1'b1, 1'b0, 2'd1));
    wr(A_CTRL, 32'h30);
    wr(A_CMD, 32'd1);
    rd(A_STAT, s);
    check("R3 start ignored disabled", s[2:0], 32'd0);
    check("R3 no valid when disabled", 32'(cmd_valid), 32'd0);
    wr(A_CTRL, 32'h31);
    wr(A_CMD, 32'd1);
    pulse(1'b0, "R4");
    wr(A_CTRL, 32'h71);
    wr(A_CMD, 32'd1);
    rd(A_STAT, s);
    check("R3 restart ignored", s, 32'h3004);
    pulse(1'b0, "R4");
    pulse(1'b0, "R4");
    pulse(1'b1, "R4");
    wr(A_STAT, 32'h3);

    for (int e = 0; e < 6; e++) begin
      case (e)
        0: dd[0] = mk(15'd2, 1'b1, 4'd0, 2'd0, 1'b1, 1'b1, 2'd1);
        1: dd[0] = mk(15'd2, 1'b1, 4'd0, 2'd0, 1'b1, 1'b1, 2'd2);
        2: dd[0] = mk(15'd2, 1'b1, 4'd0, 2'd0, 1'b1, 1'b1, 2'd3);
        3: dd[0] = mk(15'd2, 1'b1, 4'd0, 2'd3, 1'b1, 1'b0, 2'd1);
        4: dd[0] = mk(15'd0, 1'b1, 4'd0, 2'd0, 1'b1, 1'b0, 2'd1);
        default: dd[0] = mk(15'd1, 1'b1, 4'd0, 2'd2, 1'b1, 1'b1, 2'd0);
      endcase
      wr(5'd5, dd[0]);
      wr(A_CTRL, 32'h51);
      wr(A_CMD, 32'd1);
      if (e < 5) begin
        check("R6 no valid on error", 32'(cmd_valid), 32'd0);
        @(negedge clk);
        rd(A_STAT, s);
        check("R6 error status", s, 32'h5002);
        check("R6 cs idle", 32'(cs_n), 32'd1);
      end else begin
        pulse(1'b1, "R6 legal rx");
        rd(A_STAT, s);
        check("R6 legal rx status", s, 32'h5001);
      end
      wr(A_STAT, 32'h3);
    end

    wr(5'd4, mk(15'd5, 1'b1, 4'd0, 2'd1, 1'b1, 1'b0, 2'd1));
    wr(A_CTRL, 32'h41);
    wr(A_CMD, 32'd1);
    pulse(1'b0, "R8");
    pulse(1'b0, "R8");
    wr(A_CMD, 32'd2);
    rd(A_STAT, s);
    check("R8 stop pending still active", s, 32'h4004);
    check("R8 stop pending valid", 32'(cmd_valid), 32'd1);
    pulse(1'b0, "R8 stop boundary");
    rd(A_STAT, s);
    check("R8 stopped status", s, 32'h4001);
    check("R8 stopped cs_n", 32'(cs_n), 32'd1);
    wr(A_STAT, 32'h3);

    wr(5'd9, mk(15'd2, 1'b1, 4'd0, 2'd0, 1'b0, 1'b0, 2'd1));
    wr(A_CTRL, 32'h91);
    wr(A_CMD, 32'd1);
    pulse(1'b0, "R7");
    pulse(1'b1, "R7");
    check("R7 hold after chain", 32'(cs_n), 32'd0);
    check("R7 hold no valid", 32'(cmd_valid), 32'd0);
    wr(A_CMD, 32'd2);
    check("R8 idle stop releases", 32'(cs_n), 32'd1);
    wr(A_STAT, 32'h3);

    wr(5'd2, mk(15'd1, 1'b1, 4'd0, 2'd0, 1'b1, 1'b0, 2'd1));
    wr(A_CTRL, 32'h21);
    wr(A_CMD, 32'd1);
    @(negedge clk);
    unit_done = 1'b1; bus_wr = 1'b1; bus_addr = A_STAT; bus_wdata = 32'h3;
    @(negedge clk);
    unit_done = 1'b0; bus_wr = 1'b0;
    rd(A_STAT, s);
    check("R9 set beats clear", s, 32'h2001);
    wr(A_STAT, 32'h3);

    wr(5'd0, mk(15'h7FFF, 1'b1, 4'd0, 2'd0, 1'b1, 1'b0, 2'd1));
    wr(A_CTRL, 32'h01);
    wr(A_CMD, 32'd1);
    hits = 0; hit_at = 0;
    @(negedge clk);
    unit_done = 1'b1;
    for (int n = 1; n <= 32767; n++) begin
      #1;
      if (cmd_done) begin hits++; hit_at = n; end
      @(negedge clk);
    end
    unit_done = 1'b0;
    check("R4 max count hits", 32'(hits), 32'd1);
    check("R4 max count position", 32'(hit_at), 32'd32767);
    rd(A_STAT, s);
    check("R4 max count done", s, 32'h0001);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule